// File: doc/BRIEF.md
# Double-Buffered Serial-to-Parallel Output Register

This block collects a serial bit stream into a chain of shift stages and, on command, copies the whole chain into a storage register that drives a row of parallel open-drain style pins. Each pin can either pull low or float. It never drives high. Because the storage stage is separate from the shift stages, new data can be shifted in while the pins keep showing the previous pattern. The last shift stage also appears on a push-pull serial output, so several blocks can be chained into one longer register.

The shift clock and the register clock are slow control pins sampled by a fast system clock. Each of them passes through a two-flop synchroniser and then a small edge-tracking state machine. That machine has two states, `ST_LOW` and `ST_HIGH`. The transition `ST_LOW -> ST_HIGH` happens when the synchronised level is seen high, and in that cycle it emits a one-cycle rise pulse. The transition `ST_HIGH -> ST_LOW` happens when the synchronised level is seen low, and it emits nothing. A rising pin therefore acts on the third system-clock edge after it is first sampled.

An active-low clear acts at once on the shift stages and on the serial output. It leaves the storage register alone. An active-high output enable floats every pin.

Top module: `ser_par_outreg`

## Requirements
- R1: On a detected rising edge of `shift_clk_i` with clear inactive, `ser_i` enters stage 0. Every stage n moves to stage n+1. Between such edges the stages hold their values.
- R2: `ser_o` always equals the last shift stage (stage 7 with default parameters).
- R3: While `clr_n_i` is low, all shift stages and `ser_o` are 0, starting at once without waiting for a clock edge. The storage register and the pins do not change.
- R4: On a detected rising edge of `reg_clk_i`, storage bit i takes the value of shift stage i. At all other times storage holds, so shifting alone never changes the pins.
- R5: While `oe_i` is high, every `pad_o` bit is Z and every `pull_low_o` bit is 0.
- R6: While `oe_i` is low, a storage bit of 0 gives `pull_low_o[i]=1` and `pad_o[i]=0`. A storage bit of 1 gives `pull_low_o[i]=0` and `pad_o[i]=Z`.
- R7: When both clock edges are detected in the same system cycle, storage receives the contents from before that shift.
- R8: After system reset, all shift stages are 0 and all storage bits are 1, so no pin pulls low.
- R9: A shift-clock pin held high for many system cycles causes exactly one shift.
- R10: Rising shift-clock edges that arrive while clear is low are lost, and the stages stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used for sampling |
| rst_n | input | 1 | Active-low system reset |
| ser_i | input | 1 | Serial data in |
| shift_clk_i | input | 1 | Shift clock pin; a rising edge shifts |
| reg_clk_i | input | 1 | Register clock pin; a rising edge loads storage |
| clr_n_i | input | 1 | Active-low asynchronous clear of the shift stages |
| oe_i | input | 1 | Active-high output float |
| ser_o | output | 1 | Cascade output taken from the last shift stage |
| pull_low_o | output | 8 | Per-pin flag: 1 means the pin pulls low |
| pad_o | output | 8 | Tri-state pin value: 0 or Z |

## Verification
The assertions assume that the shift- and register-clock pins are low when system reset is released. They also assume that `ser_i` stays stable for the three system cycles a shift edge needs to pass through the synchroniser, and that `clr_n_i` is released with clock edges at least a few system cycles away. The stimulus holds `ser_i` steady from before a shift pin rises until after that pin falls. It keeps every pin level for four system cycles. It changes inputs only on the falling system edge, and it lowers the pins before reset is released.

// File: rtl/ser_par_pkg.sv
package ser_par_pkg;
    typedef enum logic {
        ST_LOW  = 1'b0,
        ST_HIGH = 1'b1
    } edge_state_t;

    localparam int unsigned DEF_STAGES = 8;
endpackage

// File: rtl/sp_edge_fsm.sv
module sp_edge_fsm
    import ser_par_pkg::*;
#(
    parameter int unsigned SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    localparam int unsigned SYNC_MSB = SYNC_DEPTH - 1;

    logic [SYNC_MSB:0] sync_q;
    logic              lvl;
    edge_state_t       state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_MSB-1:0], pin_i};
    end

    assign lvl = sync_q[SYNC_MSB];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_LOW;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOW:  if (lvl)  state_d = ST_HIGH;
            ST_HIGH: if (!lvl) state_d = ST_LOW;
            default: state_d = ST_LOW;
        endcase
    end

    // outputs
    always_comb begin
        rise_o = 1'b0;
        unique case (state_q)
            ST_LOW:  rise_o = lvl;
            ST_HIGH: rise_o = 1'b0;
            default: rise_o = 1'b0;
        endcase
    end

    // R9: one pulse per rising level, never two in a row
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/sp_shift_chain.sv
module sp_shift_chain #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              shift_pulse,
    input  logic              ser_in,
    output logic [STAGES-1:0] stage_q
);
    localparam int unsigned LAST = STAGES - 1;

    logic clr_lo;
    assign clr_lo = rst_n & clr_n;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic next_bit;
        if (i == 0) begin : g_head
            assign next_bit = ser_in;
        end else begin : g_body
            assign next_bit = stage_q[i-1];
        end
        always_ff @(posedge clk or negedge clr_lo) begin
            if (!clr_lo)          stage_q[i] <= 1'b0;
            else if (shift_pulse) stage_q[i] <= next_bit;
        end
    end

    p_shift_r1: assert property (@(posedge clk) disable iff (!clr_lo)
        shift_pulse |=> stage_q == {$past(stage_q[LAST-1:0]), $past(ser_in)});
    p_hold_r1: assert property (@(posedge clk) disable iff (!clr_lo)
        !shift_pulse |=> $stable(stage_q));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> stage_q == '0);
endmodule

// File: rtl/sp_store_drive.sv
module sp_store_drive #(
    parameter int unsigned STAGES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_pulse,
    input  logic              oe,
    input  logic [STAGES-1:0] shift_q,
    output logic [STAGES-1:0] pull_low,
    output logic [STAGES-1:0] pad
);
    logic [STAGES-1:0] store_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          store_q[i] <= 1'b1;
            else if (load_pulse) store_q[i] <= shift_q[i];
        end
        assign pull_low[i] = !oe && !store_q[i];
        assign pad[i]      = pull_low[i] ? 1'b0 : 1'bz;
    end

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_pulse |=> store_q == $past(shift_q));
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !load_pulse |=> $stable(store_q));
endmodule

// File: rtl/ser_par_outreg.sv
module ser_par_outreg
    import ser_par_pkg::*;
#(
    parameter int unsigned STAGES = DEF_STAGES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_i,
    input  logic              shift_clk_i,
    input  logic              reg_clk_i,
    input  logic              clr_n_i,
    input  logic              oe_i,
    output logic              ser_o,
    output logic [STAGES-1:0] pull_low_o,
    output logic [STAGES-1:0] pad_o
);
    localparam int unsigned LAST = STAGES - 1;

    logic              shift_rise, reg_rise;
    logic [STAGES-1:0] stages;

    sp_edge_fsm #(.SYNC_DEPTH(2)) u_shift_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(shift_clk_i), .rise_o(shift_rise));

    sp_edge_fsm #(.SYNC_DEPTH(2)) u_reg_edge (
        .clk(clk), .rst_n(rst_n), .pin_i(reg_clk_i), .rise_o(reg_rise));

    sp_shift_chain #(.STAGES(STAGES)) u_chain (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n_i), .shift_pulse(shift_rise),
        .ser_in(ser_i), .stage_q(stages));

    sp_store_drive #(.STAGES(STAGES)) u_store (
        .clk(clk), .rst_n(rst_n), .load_pulse(reg_rise), .oe(oe_i),
        .shift_q(stages), .pull_low(pull_low_o), .pad(pad_o));

    assign ser_o = stages[LAST];

    p_float_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe_i |-> pull_low_o == '0);
    p_clr_ser_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_i |-> !ser_o);
    p_clr_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_n_i && !reg_rise && $stable(oe_i)) |=> $stable(pull_low_o));
endmodule

// File: tb/ser_par_outreg_tb_top.sv
module ser_par_outreg_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int NVEC = 22;
    // encoding: [3:2] op (0 shift, 1 load, 2 both, 3 clear), [1] serial bit, [0] oe
    localparam logic [3:0] VEC [NVEC] = '{
        4'b0010, 4'b0000, 4'b0010, 4'b0010, 4'b0000, 4'b0000, 4'b0010, 4'b0000,
        4'b0100, 4'b0101, 4'b0011, 4'b0001, 4'b0100, 4'b1010, 4'b0100, 4'b1100,
        4'b0000, 4'b0100, 4'b0010, 4'b1000, 4'b0000, 4'b0100};

    logic clk = 0, rst_n = 0, ser_i = 0, shift_clk_i = 0, reg_clk_i = 0;
    logic clr_n_i = 1, oe_i = 0;
    logic ser_o;
    logic [W-1:0] pull_low_o, pad_o;
    logic [W-1:0] m_sh, m_st;
    int checks = 0, errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ser_par_outreg #(.STAGES(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_i(ser_i), .shift_clk_i(shift_clk_i),
        .reg_clk_i(reg_clk_i), .clr_n_i(clr_n_i), .oe_i(oe_i), .ser_o(ser_o),
        .pull_low_o(pull_low_o), .pad_o(pad_o));

    task automatic check_outs(input string tag);
        logic [W-1:0] e_pl, e_pad;
        for (int i = 0; i < W; i++) begin
            e_pl[i]  = !oe_i && !m_st[i];
            e_pad[i] = e_pl[i] ? 1'b0 : 1'bz;
        end
        checks++;
        if (ser_o !== m_sh[W-1]) begin
            errors++; $display("FAIL %s ser_o: got %b exp %b", tag, ser_o, m_sh[W-1]);
        end
        checks++;
        if (pull_low_o !== e_pl || pad_o !== e_pad) begin
            errors++;
            $display("FAIL %s pins: got pl=%b pad=%b exp pl=%b pad=%b", tag, pull_low_o, pad_o, e_pl, e_pad);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_op(input logic [1:0] op, input logic b);
        ser_i = b;
        if (op == 2'd3) begin
            clr_n_i = 0; m_sh = '0;
            #1 check_outs("R3 async clear");
            settle(3); clr_n_i = 1; settle(3);
            return;
        end
        if (op == 2'd1 || op == 2'd2) begin reg_clk_i = 1; m_st = m_sh; end
        if (op == 2'd0 || op == 2'd2) begin shift_clk_i = 1; m_sh = {m_sh[W-2:0], b}; end
        settle(4);
        shift_clk_i = 0; reg_clk_i = 0;
        settle(4);
    endtask

    initial begin
        m_sh = '0; m_st = '1;
        settle(3); rst_n = 1; settle(2);
        check_outs("R8 reset state");
        for (int k = 0; k < NVEC; k++) begin
            oe_i = VEC[k][0];
            do_op(VEC[k][3:2], VEC[k][1]);
            check_outs($sformatf("R1 R2 R4 R5 R6 R7 vector %0d", k));
        end
        // R9: long high pulse gives one shift
        oe_i = 0; ser_i = 1; shift_clk_i = 1; m_sh = {m_sh[W-2:0], 1'b1};
        settle(40); shift_clk_i = 0; settle(4);
        check_outs("R9 single shift");
        // R10: shift edges blocked while clear is low, storage kept
        do_op(2'd1, 1'b0);
        clr_n_i = 0; m_sh = '0;
        ser_i = 1; shift_clk_i = 1; settle(4); shift_clk_i = 0; settle(4);
        check_outs("R10 shift during clear");
        clr_n_i = 1; settle(4);
        do_op(2'd1, 1'b0);
        check_outs("R10 empty after clear");
        // R5: float every pin with loaded zeros
        oe_i = 1; settle(1);
        check_outs("R5 all float");
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule